// File: doc/BRIEF.md
# Paired-Timer PWM Combiner

This block turns the interval pulses of two timer channels into one pulse-width-modulated output. Channel 0 marks the start of every period. Channel 1 marks the point inside the period where the output falls. Each time channel 0 fires, the block raises the output. In the same cycle it asks channel 1 to reload and restart, so that channel 1 measures the high time from the new period boundary.

The counters sit outside this block. Their intervals set the waveform. When a counter counts down, its interval is its load value plus two clocks. When it counts up, the interval is the full-scale count minus the load value, plus two clocks. PWM works in either direction.

The block drives the output only when both channels are fit for PWM:
- both are in generate mode, not capture mode;
- both have their generate output and their PWM enable set;
- both counters are running;
- both generate outputs are built active-high.

In every other case the output is held low. When the block is built with a single channel, the PWM function does not exist and both outputs are tied low.

Top module: `pwm_pair_combiner`

## Requirements
- R1: The block is active only when, for each of channel 0 and channel 1, the capture-mode bit is 0 and the generate-enable, PWM-enable and running bits are all 1. If any one of these eight conditions fails, `pwm_out` and `ch1_restart` are 0.
- R2: If either `GEN0_ACTIVE_HIGH` or `GEN1_ACTIVE_HIGH` is 0, the block is never active. Its outputs then stay 0 whatever the inputs are.
- R3: While active, a 1 on `ch0_pulse` makes `pwm_out` equal to 1 from the next cycle.
- R4: While active, a 1 on `ch1_pulse` with `ch0_pulse` at 0 makes `pwm_out` equal to 0 from the next cycle.
- R5: If both pulses are 1 in the same cycle, the channel 0 pulse wins and the output is high in the next cycle. A high time equal to or longer than the period therefore keeps the output high.
- R6: `ch1_restart` is 1 exactly in the cycles where the block is active and `ch0_pulse` is 1.
- R7: In any cycle where the block is not active, `pwm_out` is 0 in that same cycle. After the block becomes active again, the output stays low until the next channel 0 pulse.
- R8: With `BOTH_CHANNELS` = 0, `pwm_out` and `ch1_restart` are always 0.
- R9: While `rst_n` is low, and after its release until the first channel 0 pulse, `pwm_out` is 0.
- R10: While active, in a cycle with neither pulse, the output level is carried unchanged into the next cycle. A channel 0 pulse followed by a channel 1 pulse H cycles later gives a high time of exactly H cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch0_pulse | input | 1 | Channel 0 interval pulse, one cycle wide, active-high |
| ch1_pulse | input | 1 | Channel 1 interval pulse, one cycle wide, active-high |
| ch_capture_mode | input | 2 | Per-channel mode bit: 1 = capture mode, 0 = generate mode |
| ch_gen_en | input | 2 | Per-channel generate-output enable |
| ch_pwm_en | input | 2 | Per-channel PWM enable |
| ch_running | input | 2 | Per-channel counter-running state |
| pwm_out | output | 1 | PWM waveform |
| ch1_restart | output | 1 | Request to channel 1 to reload and restart, same cycle as the channel 0 pulse |

## Verification
The bench feeds pulse trains with short and long high times. A design that gave channel 1 priority on a tie would drop the output for a cycle when the high time equals the period. One that did not latch the level between pulses would give the wrong duty.

Each of the eight enabling conditions is removed in turn while pulses keep arriving. A design that checked only some of them would let the waveform through.

Re-enabling in the middle of a period catches a design that resumes a stale high level. Two extra builds, one with an active-low generate output and one with a single channel, catch outputs that are not tied low.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef struct packed {
    logic capture_mode;
    logic gen_en;
    logic pwm_en;
    logic running;
  } chan_cfg_t;

  function automatic logic chan_fit(chan_cfg_t c);
    return !c.capture_mode && c.gen_en && c.pwm_en && c.running;
  endfunction
endpackage

// File: rtl/pwmc_qualify.sv
module pwmc_qualify
  import pwmc_pkg::*;
#(
  parameter bit GEN0_HIGH = 1'b1,
  parameter bit GEN1_HIGH = 1'b1
) (
  input  chan_cfg_t [NUM_CH-1:0] cfg,
  output logic                   active
);
  localparam bit POLARITY_OK = GEN0_HIGH && GEN1_HIGH;

  logic [NUM_CH-1:0] fit;

  // each channel must independently be fit for PWM (R1)
  for (genvar i = 0; i < NUM_CH; i++) begin : g_fit
    assign fit[i] = chan_fit(cfg[i]);
  end

  // polarity is fixed at build time (R2)
  assign active = POLARITY_OK && (&fit);
endmodule

// File: rtl/pwmc_level.sv
module pwmc_level (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic p0,
  input  logic p1,
  output logic level_q,
  output logic restart
);
  always_ff @(posedge clk) begin
    if (!rst_n)      level_q <= 1'b0;
    else if (!active) level_q <= 1'b0;
    else if (p0)     level_q <= 1'b1;
    else if (p1)     level_q <= 1'b0;
  end

  assign restart = active && p0;

  // a rising level must come from a period boundary (R6)
  assert_rise_from_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_q) |-> $past(restart));

  // inactivity clears the held level (R7)
  assert_idle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !level_q);

  // no pulse: level carried (R10)
  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !p0 && !p1) |=> (level_q == $past(level_q)));
endmodule

// File: rtl/pwm_pair_combiner.sv
module pwm_pair_combiner
  import pwmc_pkg::*;
#(
  parameter bit BOTH_CHANNELS    = 1'b1,
  parameter bit GEN0_ACTIVE_HIGH = 1'b1,
  parameter bit GEN1_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch0_pulse,
  input  logic       ch1_pulse,
  input  logic [1:0] ch_capture_mode,
  input  logic [1:0] ch_gen_en,
  input  logic [1:0] ch_pwm_en,
  input  logic [1:0] ch_running,
  output logic       pwm_out,
  output logic       ch1_restart
);
  if (BOTH_CHANNELS) begin : g_pair
    chan_cfg_t [NUM_CH-1:0] cfg;
    logic active;
    logic level_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pack
      assign cfg[i] = '{capture_mode: ch_capture_mode[i], gen_en: ch_gen_en[i],
                        pwm_en: ch_pwm_en[i], running: ch_running[i]};
    end

    pwmc_qualify #(.GEN0_HIGH(GEN0_ACTIVE_HIGH), .GEN1_HIGH(GEN1_ACTIVE_HIGH)) u_qual (
      .cfg    (cfg),
      .active (active)
    );

    pwmc_level u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .p0      (ch0_pulse),
      .p1      (ch1_pulse),
      .level_q (level_q),
      .restart (ch1_restart)
    );

    assign pwm_out = level_q && active;

    assert_ch0_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ch0_pulse) |=> (pwm_out || !active));

    assert_ch1_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ch1_pulse && !ch0_pulse) |=> !pwm_out);

    assert_tie_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ch1_pulse && ch0_pulse) |=> (pwm_out || !active));
  end else begin : g_single
    logic unused_inputs;
    assign unused_inputs = ^{ch0_pulse, ch1_pulse, ch_capture_mode, ch_gen_en,
                             ch_pwm_en, ch_running, clk, rst_n};
    // single-channel build has no PWM (R8)
    assign pwm_out     = 1'b0;
    assign ch1_restart = 1'b0;
  end
endmodule

// File: tb/tb_pwm_pair_combiner.sv
`timescale 1ns/1ps
module tb_pwm_pair_combiner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic g0 = 1'b0, g1 = 1'b0;
  logic [1:0] cap = 2'b00, gen = 2'b11, pen = 2'b11, run = 2'b11;
  logic pwm, rst_req, pwm_pol, rst_pol, pwm_one, rst_one;

  always #2 clk = ~clk;

  pwm_pair_combiner dut (
    .clk(clk), .rst_n(rst_n), .ch0_pulse(g0), .ch1_pulse(g1),
    .ch_capture_mode(cap), .ch_gen_en(gen), .ch_pwm_en(pen), .ch_running(run),
    .pwm_out(pwm), .ch1_restart(rst_req));

  pwm_pair_combiner #(.GEN1_ACTIVE_HIGH(1'b0)) dut_pol (
    .clk(clk), .rst_n(rst_n), .ch0_pulse(g0), .ch1_pulse(g1),
    .ch_capture_mode(cap), .ch_gen_en(gen), .ch_pwm_en(pen), .ch_running(run),
    .pwm_out(pwm_pol), .ch1_restart(rst_pol));

  pwm_pair_combiner #(.BOTH_CHANNELS(1'b0)) dut_one (
    .clk(clk), .rst_n(rst_n), .ch0_pulse(g0), .ch1_pulse(g1),
    .ch_capture_mode(cap), .ch_gen_en(gen), .ch_pwm_en(pen), .ch_running(run),
    .pwm_out(pwm_one), .ch1_restart(rst_one));

  typedef struct {
    logic  pwm;
    logic  restart;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  logic model_q = 1'b0;
  bit done = 1'b0;

  function automatic logic bench_active();
    return (cap == 2'b00) && (&gen) && (&pen) && (&run);
  endfunction

  // driver: apply one cycle of stimulus, push the expected outputs
  task automatic step(input logic p0, input logic p1, input string tag);
    exp_t e;
    logic act;
    @(posedge clk); #1;
    g0 = p0; g1 = p1;
    act = bench_active();
    e.pwm = act && model_q;
    e.restart = act && p0;
    e.tag = tag;
    sb.push_back(e);
    if (!act)    model_q = 1'b0;
    else if (p0) model_q = 1'b1;
    else if (p1) model_q = 1'b0;
  endtask

  task automatic run_pwm(input int per, input int high, input int reps, input string tag);
    for (int k = 0; k < reps; k++)
      for (int c = 0; c < per; c++)
        step(c == 0, (high <= per) && (c == (high % per)), tag);
  endtask

  // monitor: compare against the scoreboard half a cycle after each edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (pwm !== e.pwm || rst_req !== e.restart) begin
          failures++;
          $display("FAIL %s pwm=%b restart=%b expected pwm=%b restart=%b",
                   e.tag, pwm, rst_req, e.pwm, e.restart);
        end
        checks++;
        if (pwm_pol !== 1'b0 || rst_pol !== 1'b0) begin
          failures++;
          $display("FAIL R2 pwm=%b restart=%b expected pwm=0 restart=0", pwm_pol, rst_pol);
        end
        checks++;
        if (pwm_one !== 1'b0 || rst_one !== 1'b0) begin
          failures++;
          $display("FAIL R8 pwm=%b restart=%b expected pwm=0 restart=0", pwm_one, rst_one);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    g0 = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pwm !== 1'b0) begin
      failures++;
      $display("FAIL R9 pwm=%b expected 0 during reset", pwm);
    end
    @(posedge clk); #1;
    g0 = 1'b0; rst_n = 1'b1;
    step(0, 0, "R9 after reset");
    step(0, 1, "R9 ch1 only after reset");
    step(0, 0, "R9 idle");

    run_pwm(6, 2, 3, "R3 R4 R10 R6 duty 2/6");
    run_pwm(9, 7, 2, "R10 duty 7/9");
    run_pwm(4, 1, 2, "R4 duty 1/4");
    run_pwm(5, 5, 3, "R5 high equals period");
    run_pwm(5, 8, 2, "R5 high exceeds period");
    step(0, 1, "R4 lone ch1 pulse");
    step(0, 0, "R10 hold low");

    for (int f = 0; f < 4; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        step(1, 0, "R3 before disable");
        @(posedge clk); #1;
        case (f)
          0: cap[ch] = 1'b1;
          1: gen[ch] = 1'b0;
          2: pen[ch] = 1'b0;
          default: run[ch] = 1'b0;
        endcase
        sb.push_back('{pwm: 1'b0, restart: 1'b0, tag: "R1 R7 disabled"});
        g0 = 1'b0; g1 = 1'b0; model_q = 1'b0;
        run_pwm(4, 2, 2, "R1 condition missing");
        @(posedge clk); #1;
        cap = 2'b00; gen = 2'b11; pen = 2'b11; run = 2'b11;
        sb.push_back('{pwm: 1'b0, restart: 1'b0, tag: "R7 re-enabled"});
        step(0, 0, "R7 waits for ch0");
        step(0, 0, "R7 waits for ch0");
        step(1, 0, "R7 R6 ch0 after re-enable");
        step(0, 0, "R7 high after ch0");
        step(0, 1, "R4 after re-enable");
        step(0, 0, "R4 low");
      end
    end

    step(0, 0, "R10 final");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule